// File: doc/BRIEF.md
# Two-Threshold Signal-Strength History Recorder

This block keeps a short history of received signal strength measured against two programmable thresholds. Two comparator results arrive as digital levels, one per threshold. Together the two thresholds divide the received level into low, medium and high bands. Each comparator level passes through a two-flop synchroniser. Once per fixed time slot, the synchronised level is shifted into an 8-bit history for that threshold. The newest sample enters at bit 7. With the default divider, one slot is 128 µs of a 50 MHz clock.

A host reaches the block through a small register port with two addresses. Address 0 is the control register. It holds the enable in bit 4 and shows the live threshold indicators in bits 1:0. Address 1 is the recorder register. It holds the two 3-bit threshold codes and both histories. Any write to the recorder register clears the histories. When the radio reports transmitter role, power off and chip enable low, the history field of address 1 reads a fixed 16-bit identifier instead of the histories. The block also drives each threshold code to the analog side and reports the threshold level in dBm that the code selects.

Top module: `rssi_hist_rec`

## Requirements
- R1: After reset, the enable is 0, both threshold codes are 000, both histories are 0 and address 0 reads 0.
- R2: Bit 4 of address 0 is the recorder enable. A write to address 0 loads it, and a read of address 0 returns it.
- R3: Address 0 bit 0 shows the threshold-1 indicator and bit 1 the threshold-2 indicator. Each indicator follows its comparator two clock edges after the comparator changes. Both indicators read 0 while the enable is 0.
- R4: While enabled, each history shifts right once every SLOT_CYCLES clocks and takes the current indicator into bit 7. The first shift comes SLOT_CYCLES clock edges after the edge that wrote the enable or the recorder register.
- R5: While disabled, the slot timer stays in reset and neither history changes.
- R6: A write to address 1 clears both histories and restarts the slot timer. The same write loads the threshold-1 code from bits 18:16 and the threshold-2 code from bits 21:19. Both codes read back at those positions and appear on the code outputs.
- R7: Address 1 returns history 1 in bits 7:0 and history 2 in bits 15:8. When the radio role input, the power input and the chip-enable input are all 0, bits 15:0 read 0x7241 instead, with 0x72 in bits 15:8.
- R8: The threshold-1 level output equals −69 + 4·code dBm and the threshold-2 level output equals −59 + 4·code dBm, both as signed 8-bit values.
- R9: A threshold code of 111 marks that threshold as out of range. Its indicator reads 0 and it records 0 into its history, whatever its comparator does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_thr1_i | input | 1 | Comparator result for threshold 1 (asynchronous) |
| cmp_thr2_i | input | 1 | Comparator result for threshold 2 (asynchronous) |
| radio_rx_role_i | input | 1 | Radio is in receiver role |
| radio_pwr_i | input | 1 | Radio is powered up |
| radio_ce_i | input | 1 | Radio chip enable |
| host_addr_i | input | 1 | Register select: 0 control, 1 recorder |
| host_we_i | input | 1 | Single-cycle write strobe |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data for the selected register (combinational) |
| thr1_sel_o | output | 3 | Threshold-1 code to the analog side |
| thr2_sel_o | output | 3 | Threshold-2 code to the analog side |
| thr1_dbm_o | output | 8 | Threshold-1 level in dBm, signed |
| thr2_dbm_o | output | 8 | Threshold-2 level in dBm, signed |

## Verification
The assertions assume three things about the inputs. Host address, write strobe and radio status are synchronous to the clock. A write strobe lasts one cycle. The comparator levels may be asynchronous, because the assertions only look at them after the synchroniser. The bench changes every input on the falling edge. It holds each comparator level for a whole slot, so each sample sees a settled value after the two-flop delay. It also checks the indicator both one edge and two edges after a change.

// File: rtl/rssi_rec_pkg.sv
package rssi_rec_pkg;

  localparam int unsigned N_THR   = 2;
  localparam int unsigned HIST_W  = 8;
  localparam int unsigned SEL_W   = 3;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_REC  = 1'b1
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 4;
  localparam int unsigned REC_SEL_LSB  = 16;
  localparam logic [SEL_W-1:0] SEL_OOR = 3'b111;

  typedef logic [N_THR-1:0][SEL_W-1:0]  sel_arr_t;
  typedef logic [N_THR-1:0][HIST_W-1:0] hist_arr_t;

  function automatic logic signed [7:0] code_to_dbm(input logic signed [7:0] base,
                                                   input logic [SEL_W-1:0] code,
                                                   input logic [2:0] step_db);
    logic [7:0] ofs;
    ofs = 8'(code) * 8'(step_db);
    return base + $signed(ofs);
  endfunction

endpackage

// File: rtl/rssi_sync.sv
module rssi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/rssi_slot_timer.sv
module rssi_slot_timer #(
  parameter int unsigned SLOT_CYCLES = 6400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (restart_i || !run_i) cnt_d = '0;
    else if (at_last)        cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = run_i && !restart_i && at_last;
endmodule

// File: rtl/rssi_hist_chan.sv
module rssi_hist_chan #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             tick_i,
  input  logic             sample_i,
  output logic [WIDTH-1:0] hist_o
);
  logic [WIDTH-1:0] hist_q;
  logic [WIDTH-1:0] hist_d;
  logic             hist_en;

  assign hist_en = flush_i || tick_i;

  always_comb begin
    if (flush_i) hist_d = '0;
    else         hist_d = {sample_i, hist_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (hist_en) hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/rssi_hist_rec.sv
module rssi_hist_rec
  import rssi_rec_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES   = 6400,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter logic [15:0] CHIP_ID       = 16'h7241,
  parameter int          THR1_BASE_DBM = -69,
  parameter int          THR2_BASE_DBM = -59,
  parameter int unsigned STEP_DB       = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmp_thr1_i,
  input  logic        cmp_thr2_i,
  input  logic        radio_rx_role_i,
  input  logic        radio_pwr_i,
  input  logic        radio_ce_i,
  input  logic        host_addr_i,
  input  logic        host_we_i,
  input  logic [31:0] host_wdata_i,
  output logic [31:0] host_rdata_o,
  output logic [2:0]  thr1_sel_o,
  output logic [2:0]  thr2_sel_o,
  output logic signed [7:0] thr1_dbm_o,
  output logic signed [7:0] thr2_dbm_o
);
  localparam logic signed [7:0] BASE1 = 8'(THR1_BASE_DBM);
  localparam logic signed [7:0] BASE2 = 8'(THR2_BASE_DBM);
  localparam logic [2:0]        STEP  = 3'(STEP_DB);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // host decode
  reg_addr_e addr;
  logic      wr_ctrl;
  logic      wr_rec;

  assign addr    = reg_addr_e'(host_addr_i);
  assign wr_ctrl = host_we_i && (addr == REG_CTRL);
  assign wr_rec  = host_we_i && (addr == REG_REC);

  // control state
  logic     en_q, en_d;
  sel_arr_t sel_q, sel_d;

  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (wr_ctrl) en_d = host_wdata_i[CTRL_EN_BIT];
    if (wr_rec) begin
      for (int i = 0; i < N_THR; i++) begin
        sel_d[i] = host_wdata_i[REC_SEL_LSB + SEL_W*i +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  // slot timer
  logic tick;

  rssi_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .run_i     (en_q),
    .restart_i (wr_ctrl || wr_rec),
    .tick_o    (tick)
  );

  // per-threshold path
  logic [N_THR-1:0] cmp_raw;
  logic [N_THR-1:0] cmp_sync;
  logic [N_THR-1:0] ind;
  hist_arr_t        hist_w;

  assign cmp_raw = {cmp_thr2_i, cmp_thr1_i};

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    rssi_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_n_int),
      .d_i    (cmp_raw[g]),
      .q_o    (cmp_sync[g])
    );

    assign ind[g] = en_q && cmp_sync[g] && (sel_q[g] != SEL_OOR);

    rssi_hist_chan #(.WIDTH(HIST_W)) hist_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_int),
      .flush_i  (wr_rec),
      .tick_i   (tick),
      .sample_i (ind[g]),
      .hist_o   (hist_w[g])
    );
  end

  // read mux
  logic        radio_idle;
  logic [15:0] hist_field;

  assign radio_idle = !radio_rx_role_i && !radio_pwr_i && !radio_ce_i;
  assign hist_field = radio_idle ? CHIP_ID : {hist_w[1], hist_w[0]};

  always_comb begin
    host_rdata_o = '0;
    unique case (addr)
      REG_CTRL: begin
        host_rdata_o[CTRL_EN_BIT] = en_q;
        host_rdata_o[N_THR-1:0]   = ind;
      end
      REG_REC: begin
        host_rdata_o[15:0] = hist_field;
        for (int i = 0; i < N_THR; i++) begin
          host_rdata_o[REC_SEL_LSB + SEL_W*i +: SEL_W] = sel_q[i];
        end
      end
      default: host_rdata_o = '0;
    endcase
  end

  assign thr1_sel_o = sel_q[0];
  assign thr2_sel_o = sel_q[1];
  assign thr1_dbm_o = code_to_dbm(BASE1, sel_q[0], STEP);
  assign thr2_dbm_o = code_to_dbm(BASE2, sel_q[1], STEP);

endmodule

// File: rtl/rssi_hist_rec_chk.sv
module rssi_hist_rec_chk #(
  parameter logic [15:0] CHIP_ID = 16'h7241
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_addr_i,
  input logic        host_we_i,
  input logic [31:0] host_rdata_o,
  input logic [2:0]  thr1_sel_o,
  input logic [2:0]  thr2_sel_o,
  input logic        radio_rx_role_i,
  input logic        radio_pwr_i,
  input logic        radio_ce_i,
  input logic        en_q,
  input logic [15:0] hist_i
);
  logic idle;
  assign idle = !radio_rx_role_i && !radio_pwr_i && !radio_ce_i;

  AST_ID_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && host_addr_i) |-> host_rdata_o[15:0] == CHIP_ID); // R7

  AST_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i) |=> hist_i == 16'h0000); // R6

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !(host_we_i && host_addr_i)) |=> $stable(hist_i)); // R5

  AST_OOR_IND1_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_addr_i && thr1_sel_o == 3'b111) |-> !host_rdata_o[0]); // R9

  AST_OOR_IND2_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_addr_i && thr2_sel_o == 3'b111) |-> !host_rdata_o[1]); // R9

  AST_OFF_IND_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_addr_i && !host_rdata_o[4]) |-> host_rdata_o[1:0] == 2'b00); // R3
endmodule

bind rssi_hist_rec rssi_hist_rec_chk #(.CHIP_ID(CHIP_ID)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .host_addr_i     (host_addr_i),
  .host_we_i       (host_we_i),
  .host_rdata_o    (host_rdata_o),
  .thr1_sel_o      (thr1_sel_o),
  .thr2_sel_o      (thr2_sel_o),
  .radio_rx_role_i (radio_rx_role_i),
  .radio_pwr_i     (radio_pwr_i),
  .radio_ce_i      (radio_ce_i),
  .en_q            (en_q),
  .hist_i          (hist_w)
);

// File: tb/rssi_hist_rec_tb_top.sv
module rssi_hist_rec_tb_top;
  localparam int unsigned SLOT = 16;
  localparam int unsigned NPAT = 10;
  // {cmp2, cmp1} per slot
  localparam logic [1:0] PAT [NPAT] = '{2'b01, 2'b11, 2'b10, 2'b00, 2'b11,
                                        2'b01, 2'b01, 2'b10, 2'b11, 2'b00};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp1, cmp2, role, pwr, ce;
  logic        addr, we;
  logic [31:0] wdata, rdata;
  logic [2:0]  sel1, sel2;
  logic signed [7:0] dbm1, dbm2;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  rssi_hist_rec #(.SLOT_CYCLES(SLOT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_thr1_i(cmp1), .cmp_thr2_i(cmp2),
    .radio_rx_role_i(role), .radio_pwr_i(pwr), .radio_ce_i(ce),
    .host_addr_i(addr), .host_we_i(we), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .thr1_sel_o(sel1), .thr2_sel_o(sel2), .thr1_dbm_o(dbm1), .thr2_dbm_o(dbm2));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write(input logic a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  e1, e2;
    logic [31:0] selbits;
    rst_n = 1'b0; cmp1 = 1'b0; cmp2 = 1'b0;
    role = 1'b0; pwr = 1'b1; ce = 1'b0;
    addr = 1'b0; we = 1'b0; wdata = '0;
    step(5);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    host_read(1'b0, rd); check("R1 ctrl", rd, 0);
    host_read(1'b1, rd); check("R1 rec", rd, 0);
    check("R1 sel1", int'(sel1), 0);
    check("R8 dbm1 reset", int'(dbm1), -69);
    check("R8 dbm2 reset", int'(dbm2), -59);

    // R7 identifier when idle
    pwr = 1'b0;
    host_read(1'b1, rd); check("R7 id idle", rd, 32'h0000_7241);
    pwr = 1'b1;

    // R3 indicators read 0 while disabled
    cmp1 = 1'b1; cmp2 = 1'b1;
    step(3);
    host_read(1'b0, rd); check("R3 off ind", rd, 0);
    cmp1 = 1'b0; cmp2 = 1'b0;
    step(3);

    // R2 enable
    host_write(1'b0, 32'h10);
    host_read(1'b0, rd); check("R2 enable rd", rd, 32'h10);

    // R3 two-flop latency
    cmp1 = 1'b1;
    step(1);
    host_read(1'b0, rd); check("R3 ind after 1 edge", rd, 32'h10);
    step(1);
    host_read(1'b0, rd); check("R3 ind after 2 edges", rd, 32'h11);
    cmp2 = 1'b1;
    step(2);
    host_read(1'b0, rd); check("R3 both ind", rd, 32'h13);

    // R6 flush and load codes: sel1=2, sel2=5
    host_write(1'b1, (32'd5 << 19) | (32'd2 << 16));
    selbits = 32'h002A_0000;
    host_read(1'b1, rd); check("R6 flush rd", rd, selbits);
    check("R6 sel2 out", int'(sel2), 5);
    check("R8 dbm1 code2", int'(dbm1), -61);
    check("R8 dbm2 code5", int'(dbm2), -39);

    // R4 table walk, one slot per vector
    e1 = '0; e2 = '0;
    for (int i = 0; i < NPAT; i++) begin
      cmp1 = PAT[i][0]; cmp2 = PAT[i][1];
      step(SLOT);
      e1 = {PAT[i][0], e1[7:1]};
      e2 = {PAT[i][1], e2[7:1]};
      host_read(1'b1, rd);
      check($sformatf("R4 slot %0d", i), rd, selbits | {16'h0, e2, e1});
    end

    // R5 disabled: histories hold
    host_write(1'b0, 32'h0);
    cmp1 = 1'b1; cmp2 = 1'b0;
    step(3*SLOT);
    host_read(1'b1, rd); check("R5 hold", rd, selbits | {16'h0, e2, e1});
    host_read(1'b0, rd); check("R3 off ind2", rd, 0);

    // R9 code 111 on threshold 1
    host_write(1'b0, 32'h10);
    host_write(1'b1, 32'd7 << 16);
    cmp1 = 1'b1; cmp2 = 1'b1;
    check("R8 dbm1 code7", int'(dbm1), -41);
    step(3);
    host_read(1'b0, rd); check("R9 ind masked", rd, 32'h12);
    step(2*SLOT - 3);
    host_read(1'b1, rd); check("R9 hist", rd, 32'h0007_C000);

    // R7 idle condition details
    pwr = 1'b0;
    host_read(1'b1, rd); check("R7 id enabled", rd, 32'h0007_7241);
    role = 1'b1;
    host_read(1'b1, rd); check("R7 role rx", rd, 32'h0007_C000);
    role = 1'b0; ce = 1'b1;
    host_read(1'b1, rd); check("R7 ce high", rd, 32'h0007_C000);
    ce = 1'b0; pwr = 1'b1;

    // R6 clear again
    host_write(1'b1, 32'h0);
    host_read(1'b1, rd); check("R6 second flush", rd, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule